// File: doc/BRIEF.md
# Calibration State Watchdog FSM

This block keeps track of how well the local clock of a time-triggered CAN node has been calibrated. There are three levels: uncalibrated, basic and precision. A down-counting watchdog is loaded from a programmable reload value. Each calibration level keeps the watchdog alive with its own kind of message. The bit-time and oscillator arithmetic sit elsewhere. This block sees only their results: a pulse for an ordinary received message and a pulse for a message from a quartz-controlled node. It also watches the receive line for falling edges and follows a level that says whether the protocol engine is running.

When the watchdog expires, the response depends on the level. An uncalibrated node re-arms and waits for the next falling edge. A basic node drops back to uncalibrated. A precision node drops back to basic. A small register interface sets the reload value and the interrupt enables, and it clears the two sticky event flags (timeout and level change). The interrupt line is the OR of the enabled flags.

Top module: `cal_wdog_fsm`

## Requirements
- R1: `cal_state` uses 2'b00 for uncalibrated, 2'b01 for basic and 2'b10 for precision, and never shows 2'b11. After reset, `cal_state` is 00, `wd_value` is 0, and `evt_flags`, `evt_en` and `irq` are all 0.
- R2: While uncalibrated and not armed, the watchdog stays idle and messages are ignored. The first falling edge on `rx_line` arms the block, loads `wd_value` with the reload value, and starts counting. The count drops by one on each `tick_en` cycle.
- R3: If the watchdog expires while uncalibrated, the state stays 00, `wd_value` is reloaded and then holds, counting stops until the next falling edge, and flag bit 0 is set.
- R4: While uncalibrated and armed, a pulse on `msg_rx` or `qmsg_rx` moves the state to basic (01) and reloads the watchdog.
- R5: In basic, each `msg_rx` pulse reloads the watchdog. Expiry happens on the `tick_en` cycle that sees a count of 1. It moves the state to 00, reloads the watchdog and waits for a falling edge.
- R6: In basic, a `qmsg_rx` pulse moves the state to precision (10) and reloads the watchdog. If both pulses arrive in the same cycle, the quartz pulse wins.
- R7: In precision, only `qmsg_rx` reloads the watchdog and `msg_rx` is ignored. Expiry moves the state to 01 with the watchdog reloaded and still counting.
- R8: If the watchdog expires in the same cycle as a keep-alive message, the expiry wins.
- R9: While `engine_run` is low, the state, the count and arming are all frozen, and message pulses have no effect.
- R10: A reload value of 0 disables expiry. Once the counter reaches 0 or is loaded with 0, it stays at 0 and the state is kept.
- R11: Flag bit 0 records a watchdog expiry and bit 1 records any change of `cal_state`. Both flags are sticky. Writing 1 to a bit clears that flag, and writing 0 leaves it unchanged.
- R12: `irq` is high exactly while some flag bit and its matching enable bit are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Watchdog count enable, one decrement per cycle high |
| rx_line | input | 1 | CAN receive line, idle high |
| msg_rx | input | 1 | One-cycle pulse: message received |
| qmsg_rx | input | 1 | One-cycle pulse: quartz-node message received |
| engine_run | input | 1 | Protocol engine started (init cleared) |
| reload_wr | input | 1 | Write strobe for the reload value |
| reload_din | input | 16 | Reload value to write |
| evt_clr_wr | input | 1 | Write strobe for clearing flags |
| evt_clr_din | input | 2 | Write-1-to-clear mask for the flags |
| evt_en_wr | input | 1 | Write strobe for the interrupt enables |
| evt_en_din | input | 2 | New interrupt enable bits |
| cal_state | output | 2 | Calibration level |
| wd_value | output | 16 | Current watchdog count |
| reload_val | output | 16 | Programmed reload value |
| evt_flags | output | 2 | Sticky flags: bit 0 timeout, bit 1 level change |
| evt_en | output | 2 | Interrupt enable bits |
| irq | output | 1 | Interrupt line |

## Verification
The hardest case to reach is a collision: the watchdog expires in the very cycle that a keep-alive message arrives. The bench reaches it by reloading the counter with a pulse whose edge it knows. It then lets a counted number of `tick_en` cycles pass, so that the next message pulse lands on the edge where the count is 1. The same counted approach places each expiry exactly. This shows that the demotion from precision to basic keeps the counter running, while the drop from basic to uncalibrated stops it until the receive line falls again.

// File: rtl/cal_wdog_pkg.sv
package cal_wdog_pkg;

   typedef enum logic [1:0] {
      CAL_NONE    = 2'b00,
      CAL_BASIC   = 2'b01,
      CAL_PRECISE = 2'b10
   } cal_state_e;

   localparam int EVT_TIMEOUT = 0;
   localparam int EVT_STCHG   = 1;
   localparam int EVT_NUM     = 2;

endpackage

// File: rtl/cal_rx_edge.sv
module cal_rx_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_line,
   output logic fall
);

   logic rx_cur;
   logic rx_prev_q;

   if (SYNC_STAGES == 0) begin : g_direct
      assign rx_cur = rx_line;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sync_q <= '1;
         end else begin
            sync_q[0] <= rx_line;
            for (int i = 1; i < SYNC_STAGES; i++) begin
               sync_q[i] <= sync_q[i-1];
            end
         end
      end
      assign rx_cur = sync_q[SYNC_STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rx_prev_q <= 1'b1;
      else        rx_prev_q <= rx_cur;
   end

   assign fall = rx_prev_q & ~rx_cur;

endmodule

// File: rtl/cal_wd_counter.sv
module cal_wd_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             run,
   input  logic             tick,
   input  logic [CNT_W-1:0] reload,
   output logic [CNT_W-1:0] value,
   output logic             expire
);

   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
   localparam logic [CNT_W-1:0] ZERO = '0;

   logic [CNT_W-1:0] value_q;
   logic             step;

   assign step   = run & tick;
   assign expire = step & (reload != ZERO) & (value_q <= ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         value_q <= ZERO;
      end else if (load) begin
         value_q <= reload;
      end else if (step && value_q != ZERO) begin
         value_q <= value_q - ONE;
      end
   end

   assign value = value_q;

endmodule

// File: rtl/cal_state_ctrl.sv
module cal_state_ctrl
   import cal_wdog_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       act,
   input  logic       fall,
   input  logic       msg,
   input  logic       qmsg,
   input  logic       expire,
   output cal_state_e state,
   output logic       load,
   output logic       run,
   output logic       chg
);

   cal_state_e state_q, state_d;
   logic       armed_q, armed_d;

   always_comb begin
      state_d = state_q;
      armed_d = armed_q;
      load    = 1'b0;
      if (act) begin
         unique case (state_q)
            CAL_NONE: begin
               if (expire) begin
                  armed_d = 1'b0;
                  load    = 1'b1;
               end else if (armed_q && (msg || qmsg)) begin
                  state_d = CAL_BASIC;
                  load    = 1'b1;
               end else if (!armed_q && fall) begin
                  armed_d = 1'b1;
                  load    = 1'b1;
               end
            end
            CAL_BASIC: begin
               if (expire) begin
                  state_d = CAL_NONE;
                  armed_d = 1'b0;
                  load    = 1'b1;
               end else if (qmsg) begin
                  state_d = CAL_PRECISE;
                  load    = 1'b1;
               end else if (msg) begin
                  load    = 1'b1;
               end
            end
            CAL_PRECISE: begin
               if (expire) begin
                  state_d = CAL_BASIC;
                  load    = 1'b1;
               end else if (qmsg) begin
                  load    = 1'b1;
               end
            end
            default: begin
               state_d = CAL_NONE;
               armed_d = 1'b0;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= CAL_NONE;
         armed_q <= 1'b0;
      end else begin
         state_q <= state_d;
         armed_q <= armed_d;
      end
   end

   assign state = state_q;
   assign run   = act & ((state_q != CAL_NONE) | armed_q);
   assign chg   = (state_d != state_q);

endmodule

// File: rtl/cal_evt_regs.sv
module cal_evt_regs #(
   parameter int N_EVT = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_EVT-1:0] set,
   input  logic             clr_wr,
   input  logic [N_EVT-1:0] clr_din,
   input  logic             en_wr,
   input  logic [N_EVT-1:0] en_din,
   output logic [N_EVT-1:0] flags,
   output logic [N_EVT-1:0] en,
   output logic             irq
);

   logic [N_EVT-1:0] en_q;
   logic [N_EVT-1:0] pend;

   for (genvar g = 0; g < N_EVT; g++) begin : g_flag
      logic flag_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            flag_q <= 1'b0;
         end else if (set[g]) begin
            flag_q <= 1'b1;
         end else if (clr_wr && clr_din[g]) begin
            flag_q <= 1'b0;
         end
      end
      assign flags[g] = flag_q;
      assign pend[g]  = flag_q & en_q[g];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     en_q <= '0;
      else if (en_wr) en_q <= en_din;
   end

   assign en  = en_q;
   assign irq = |pend;

endmodule

// File: rtl/cal_wdog_fsm.sv
module cal_wdog_fsm
   import cal_wdog_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             rx_line,
   input  logic             msg_rx,
   input  logic             qmsg_rx,
   input  logic             engine_run,
   input  logic             reload_wr,
   input  logic [CNT_W-1:0] reload_din,
   input  logic             evt_clr_wr,
   input  logic [1:0]       evt_clr_din,
   input  logic             evt_en_wr,
   input  logic [1:0]       evt_en_din,
   output logic [1:0]       cal_state,
   output logic [CNT_W-1:0] wd_value,
   output logic [CNT_W-1:0] reload_val,
   output logic [1:0]       evt_flags,
   output logic [1:0]       evt_en,
   output logic             irq
);

   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
      $error("cal_wdog_fsm: CNT_W must lie in 2..32");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("cal_wdog_fsm: SYNC_STAGES must lie in 0..4");
   end

   logic [CNT_W-1:0]   reload_q;
   logic               rx_fall;
   logic               ctr_load, ctr_run, ctr_expire, st_chg;
   cal_state_e         st;
   logic [EVT_NUM-1:0] evt_set;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         reload_q <= '0;
      else if (reload_wr) reload_q <= reload_din;
   end

   cal_rx_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .rx_line (rx_line),
      .fall    (rx_fall)
   );

   cal_state_ctrl u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .act    (engine_run),
      .fall   (rx_fall),
      .msg    (msg_rx),
      .qmsg   (qmsg_rx),
      .expire (ctr_expire),
      .state  (st),
      .load   (ctr_load),
      .run    (ctr_run),
      .chg    (st_chg)
   );

   cal_wd_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (ctr_load),
      .run    (ctr_run),
      .tick   (tick_en),
      .reload (reload_q),
      .value  (wd_value),
      .expire (ctr_expire)
   );

   always_comb begin
      evt_set              = '0;
      evt_set[EVT_TIMEOUT] = ctr_expire;
      evt_set[EVT_STCHG]   = st_chg;
   end

   cal_evt_regs #(.N_EVT(EVT_NUM)) u_evt (
      .clk     (clk),
      .rst_n   (rst_n),
      .set     (evt_set),
      .clr_wr  (evt_clr_wr),
      .clr_din (evt_clr_din),
      .en_wr   (evt_en_wr),
      .en_din  (evt_en_din),
      .flags   (evt_flags),
      .en      (evt_en),
      .irq     (irq)
   );

   assign cal_state  = st;
   assign reload_val = reload_q;

endmodule

// File: rtl/cal_wdog_fsm_chk.sv
module cal_wdog_fsm_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             engine_run,
   input logic [1:0]       cal_state,
   input logic [CNT_W-1:0] wd_value,
   input logic [CNT_W-1:0] reload_val,
   input logic [1:0]       evt_flags,
   input logic             evt_clr_wr,
   input logic [1:0]       evt_clr_din
);

   p_legal_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cal_state != 2'b11);

   p_basic_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cal_state == 2'b01) ##1 (cal_state == 2'b00) |-> evt_flags[0]);

   p_precise_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cal_state == 2'b10) ##1 (cal_state == 2'b01) |-> evt_flags[0]);

   p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !engine_run |=> ($stable(cal_state) && $stable(wd_value)));

   p_no_timeout_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (reload_val == '0 && !evt_flags[0]) |=> !evt_flags[0]);

   p_timeout_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_flags[0] && !(evt_clr_wr && evt_clr_din[0])) |=> evt_flags[0]);

   p_change_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_flags[1] && !(evt_clr_wr && evt_clr_din[1])) |=> evt_flags[1]);

   p_change_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cal_state) |-> evt_flags[1]);

endmodule

bind cal_wdog_fsm cal_wdog_fsm_chk #(.CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .engine_run  (engine_run),
   .cal_state   (cal_state),
   .wd_value    (wd_value),
   .reload_val  (reload_val),
   .evt_flags   (evt_flags),
   .evt_clr_wr  (evt_clr_wr),
   .evt_clr_din (evt_clr_din)
);

// File: tb/cal_wdog_fsm_bench.sv
`timescale 1ns/1ps
module cal_wdog_fsm_bench;

   localparam int RL = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b1;
   logic        rx_line = 1'b1;
   logic        msg_rx = 1'b0;
   logic        qmsg_rx = 1'b0;
   logic        engine_run = 1'b1;
   logic        reload_wr = 1'b0;
   logic [15:0] reload_din = '0;
   logic        evt_clr_wr = 1'b0;
   logic [1:0]  evt_clr_din = '0;
   logic        evt_en_wr = 1'b0;
   logic [1:0]  evt_en_din = '0;
   logic [1:0]  cal_state;
   logic [15:0] wd_value;
   logic [15:0] reload_val;
   logic [1:0]  evt_flags;
   logic [1:0]  evt_en;
   logic        irq;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   cal_wdog_fsm u_cal_wdog_fsm (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .rx_line(rx_line),
      .msg_rx(msg_rx), .qmsg_rx(qmsg_rx), .engine_run(engine_run),
      .reload_wr(reload_wr), .reload_din(reload_din),
      .evt_clr_wr(evt_clr_wr), .evt_clr_din(evt_clr_din),
      .evt_en_wr(evt_en_wr), .evt_en_din(evt_en_din),
      .cal_state(cal_state), .wd_value(wd_value), .reload_val(reload_val),
      .evt_flags(evt_flags), .evt_en(evt_en), .irq(irq)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_reload(input logic [15:0] v);
      reload_din = v; reload_wr = 1'b1; step(1); reload_wr = 1'b0;
   endtask

   task automatic clr(input logic [1:0] m);
      evt_clr_din = m; evt_clr_wr = 1'b1; step(1); evt_clr_wr = 1'b0;
   endtask

   task automatic set_en(input logic [1:0] m);
      evt_en_din = m; evt_en_wr = 1'b1; step(1); evt_en_wr = 1'b0;
   endtask

   task automatic pulse(input logic m, input logic q);
      msg_rx = m; qmsg_rx = q; step(1); msg_rx = 1'b0; qmsg_rx = 1'b0;
   endtask

   task automatic fall_edge();
      rx_line = 1'b0; step(3); rx_line = 1'b1;
   endtask

   task automatic t_reset();
      chk("R1 state after reset", cal_state, 0);
      chk("R1 count after reset", wd_value, 0);
      chk("R1 flags after reset", evt_flags, 0);
      chk("R1 enables after reset", evt_en, 0);
      chk("R1 irq after reset", irq, 0);
   endtask

   task automatic t_no_edge();
      step(20);
      chk("R2 idle count without edge", wd_value, 0);
      pulse(1, 0);
      chk("R2 message ignored before arming", cal_state, 0);
   endtask

   task automatic t_arm();
      fall_edge();
      chk("R2 load on falling edge", wd_value, RL);
      step(3);
      chk("R2 decrement per tick", wd_value, RL - 3);
   endtask

   task automatic t_none_timeout();
      step(4);
      chk("R3 count at one", wd_value, 1);
      step(1);
      chk("R3 state kept", cal_state, 0);
      chk("R3 reloaded", wd_value, RL);
      chk("R3 timeout flag", evt_flags[0], 1);
      step(5);
      chk("R3 counting stopped", wd_value, RL);
      chk("R3 no level-change flag", evt_flags[1], 0);
      clr(2'b11);
      chk("R11 clear by writing ones", evt_flags, 0);
   endtask

   task automatic t_basic();
      fall_edge();
      pulse(1, 0);
      chk("R4 promote to basic", cal_state, 1);
      chk("R4 reload on promotion", wd_value, RL);
      chk("R11 level-change flag", evt_flags[1], 1);
      step(4);
      pulse(1, 0);
      chk("R5 message restarts", wd_value, RL);
      step(7);
      chk("R5 still basic at one", cal_state, 1);
      step(1);
      chk("R5 drop to none", cal_state, 0);
      chk("R5 reloaded on drop", wd_value, RL);
      chk("R5 timeout flag", evt_flags[0], 1);
      step(4);
      chk("R5 waits for edge", wd_value, RL);
      clr(2'b11);
   endtask

   task automatic t_precise();
      fall_edge();
      pulse(1, 0);
      pulse(0, 1);
      chk("R6 promote to precision", cal_state, 2);
      chk("R6 reload on promotion", wd_value, RL);
      step(2);
      pulse(1, 0);
      chk("R7 plain message ignored", wd_value, RL - 3);
      chk("R7 state held", cal_state, 2);
      pulse(0, 1);
      chk("R7 quartz restarts", wd_value, RL);
      clr(2'b11);
      step(6);
      chk("R7 count at one", wd_value, 1);
      step(1);
      chk("R7 demote to basic", cal_state, 1);
      chk("R7 timeout flag", evt_flags[0], 1);
      step(2);
      chk("R7 counter keeps running", wd_value, RL - 2);
   endtask

   task automatic t_quartz_wins();
      pulse(1, 1);
      chk("R6 quartz wins over plain", cal_state, 2);
      step(7);
      step(1);
      chk("R7 demote again", cal_state, 1);
      chk("R7 reloaded on demote", wd_value, RL);
   endtask

   task automatic t_precedence();
      clr(2'b11);
      step(6);
      chk("R8 count at one", wd_value, 1);
      pulse(1, 0);
      chk("R8 expiry wins", cal_state, 0);
      chk("R8 timeout flag", evt_flags[0], 1);
      clr(2'b11);
   endtask

   task automatic t_engine_stop();
      fall_edge();
      pulse(1, 0);
      step(2);
      engine_run = 1'b0;
      step(10);
      chk("R9 count frozen", wd_value, RL - 2);
      chk("R9 state frozen", cal_state, 1);
      pulse(0, 1);
      chk("R9 quartz ignored", cal_state, 1);
      engine_run = 1'b1;
      step(1);
      chk("R9 resumes", wd_value, RL - 3);
   endtask

   task automatic t_irq();
      clr(2'b11);
      set_en(2'b01);
      chk("R12 no irq without flags", irq, 0);
      pulse(0, 1);
      chk("R11 change flag only", evt_flags, 2'b10);
      chk("R12 disabled flag no irq", irq, 0);
      set_en(2'b10);
      chk("R12 enabled flag irq", irq, 1);
      clr(2'b00);
      chk("R11 writing zero keeps flag", evt_flags, 2'b10);
      clr(2'b10);
      chk("R12 irq drops on clear", irq, 0);
      set_en(2'b01);
      step(4);
      chk("R7 demote in irq test", cal_state, 1);
      chk("R11 both flags", evt_flags, 2'b11);
      chk("R12 irq on timeout", irq, 1);
      clr(2'b11);
      set_en(2'b00);
   endtask

   task automatic t_reload_zero();
      wr_reload(16'd0);
      step(40);
      chk("R10 state kept", cal_state, 1);
      chk("R10 no timeout", evt_flags, 0);
      chk("R10 counter parked", wd_value, 0);
      pulse(1, 0);
      chk("R10 zero load", wd_value, 0);
      step(20);
      chk("R10 still basic", cal_state, 1);
   endtask

   initial begin
      for (int i = 0; i < 5000; i++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      t_reset();
      wr_reload(16'(RL));
      chk("R2 reload readback", reload_val, RL);
      t_no_edge();
      t_arm();
      t_none_timeout();
      t_basic();
      t_precise();
      t_quartz_wins();
      t_precedence();
      t_engine_stop();
      t_irq();
      t_reload_zero();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule